// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable model of a three-wire serial EEPROM that answers a host over a chip select, a serial clock, a data input and a data output with a separate output enable. The host frames every instruction with a start bit. The start bit is followed by a two-bit command and an address field, and writes add a data word. A strap input selects a word width of sixteen bits or of eight bits over one register-file array. In the eight-bit view each array word holds two bytes. The serial pins are brought into the system clock domain through two-flop synchronizers. The system clock must run at least four times faster than the serial clock.

Programming commands run for a set number of system-clock cycles, with one count for a single word, one for a whole-array erase and one for a whole-array fill. While a command runs, the data output reports busy or ready as long as chip select stays high. A read returns a leading zero and then the addressed word. If the clock keeps running, the following words stream out with the address incrementing. Programming needs two things: an enable command issued since reset, and the write-protect input held high.

Top module: `uw_eeprom`

## Requirements
- R1: Before a start condition, serial clock and data input activity has no effect. A start condition is the first serial clock rise with chip select and data input both high. Low data bits clocked in while chip select is high do not start a command.
- R2: The command is two bits: 10 is read, 01 is write and 11 is erase. Command 00 takes its meaning from the two most significant address bits: 11 enables programming, 00 disables it, 10 erases the whole array and 01 fills the whole array. The address field is ADDR_W bits in the 16-bit view and ADDR_W+1 bits in the 8-bit view, sent MSB first. The org input selects the view: 1 for 16-bit, 0 for 8-bit.
- R3: A read drives a 0 on the clock rise of the last address bit. It then shifts the word out MSB first, one bit per later rise. In the 8-bit view, a byte address with LSB 1 selects bits 15:8 of array word (address >> 1), and LSB 0 selects bits 7:0.
- R4: After the last bit of a word, further rises stream the next address, wrapping from the top of the view to address 0.
- R5: After reset, programming is disabled. The enable and disable commands switch it. Reads work in either state.
- R6: When the write-protect input pe is low, no programming command changes the array.
- R7: Write stores the data word at the address. Erase sets the addressed word to all ones. In the 8-bit view only the addressed byte changes.
- R8: Whole-array erase sets every word to all ones. Whole-array fill writes the data to every word, and an 8-bit fill places the byte in both halves of each word.
- R9: A command whose last bit has not been clocked in when chip select falls is not executed.
- R10: A programming command starts on the rise that clocks its last bit. While chip select is high, dout is 0 for T_WORD, T_ERAL or T_WRAL system cycles and then 1. Start bits are ignored while busy. A blocked command reports ready at once.
- R11: dout_oe is 0 after reset, while chip select is low, and after the enable and disable commands.
- R12: Reset sets every array word to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | Serial clock |
| cs | input | 1 | Chip select, active high |
| di | input | 1 | Serial data into the block |
| pe | input | 1 | Write-protect input; programming is allowed only when high |
| org | input | 1 | Word view: 1 = 16-bit, 0 = 8-bit |
| dout | output | 1 | Serial read data or ready/busy status |
| dout_oe | output | 1 | Output enable for dout; low means high-impedance |

## Verification
Every word is written in the 16-bit view with a distinct pattern and read back. Every byte address is then read in the 8-bit view, which tells apart a swapped byte lane or a wrong field length. Sequential reads that start near the top of each view show whether the address increments and wraps. Writes are also tried while disabled, while protected and after being cut short, and each case must leave the array unchanged. Busy sampling at points between the single-word and whole-array durations shows that each command selects its own timing.

// File: rtl/uw_pkg.sv
package uw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_OPC, ST_ADR, ST_DAT, ST_RD, ST_STAT
   } uw_state_t;

   typedef enum logic [1:0] {
      PG_WORD, PG_ERAL, PG_WRAL
   } uw_prog_t;

   localparam logic [1:0] CMD_READ  = 2'b10;
   localparam logic [1:0] CMD_WRITE = 2'b01;
   localparam logic [1:0] CMD_ERASE = 2'b11;
   localparam logic [1:0] CMD_EXT   = 2'b00;

   localparam logic [1:0] EXT_ENABLE  = 2'b11;
   localparam logic [1:0] EXT_DISABLE = 2'b00;
   localparam logic [1:0] EXT_ERAL    = 2'b10;
   localparam logic [1:0] EXT_WRAL    = 2'b01;
endpackage

// File: rtl/uw_sync.sv
module uw_sync #(
   parameter int N      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] dout
);
   if (STAGES < 2) begin : g_chk
      $error("uw_sync needs at least two stages");
   end

   for (genvar g = 0; g < N; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], din[g]};
      end
      assign dout[g] = chain[STAGES-1];
   end
endmodule

// File: rtl/uw_store.sv
module uw_store #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_idx,
   output logic [DATA_W-1:0] rd_word,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_idx,
   input  logic [DATA_W-1:0] wr_val,
   input  logic [DATA_W-1:0] wr_mask,
   input  logic              fill_en,
   input  logic [DATA_W-1:0] fill_val
);
   localparam int DEPTH = 1 << ADDR_W;

   if (DATA_W % 2 != 0) begin : g_chk
      $error("uw_store word width must be even");
   end

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
      end else if (fill_en) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= fill_val;
      end else if (wr_en) begin
         cells[wr_idx] <= (cells[wr_idx] & ~wr_mask) | (wr_val & wr_mask);
      end
   end

   assign rd_word = cells[rd_idx];

   AST_SINGLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && fill_en)); // R8
endmodule

// File: rtl/uw_prog_timer.sv
module uw_prog_timer
   import uw_pkg::*;
#(
   parameter int T_WORD = 2000,
   parameter int T_ERAL = 5000,
   parameter int T_WRAL = 9000
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  uw_prog_t kind,
   output logic     busy
);
   localparam int T_A  = (T_WORD > T_ERAL) ? T_WORD : T_ERAL;
   localparam int TMAX = (T_A > T_WRAL) ? T_A : T_WRAL;
   localparam int CW   = $clog2(TMAX + 1);

   if (T_WORD < 1 || T_ERAL < 1 || T_WRAL < 1) begin : g_chk
      $error("uw_prog_timer durations must be positive");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (start) begin
         unique case (kind)
            PG_ERAL: cnt <= CW'(T_ERAL);
            PG_WRAL: cnt <= CW'(T_WRAL);
            default: cnt <= CW'(T_WORD);
         endcase
      end else if (cnt != '0) cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy); // R10
endmodule

// File: rtl/uw_eeprom.sv
module uw_eeprom
   import uw_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int WORD_W = 16,
   parameter int T_WORD = 2000,
   parameter int T_ERAL = 5000,
   parameter int T_WRAL = 9000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs,
   input  logic di,
   input  logic pe,
   input  logic org,
   output logic dout,
   output logic dout_oe
);
   localparam int FLD_W  = ADDR_W + 1;
   localparam int BYTE_W = WORD_W / 2;
   localparam int MAXL   = (FLD_W > WORD_W) ? FLD_W : WORD_W;
   localparam int BC_W   = $clog2(MAXL + 1);

   if (ADDR_W < 2) begin : g_chk_addr
      $error("uw_eeprom needs at least two address bits for extended commands");
   end
   if (WORD_W != 16) begin : g_chk_word
      $error("uw_eeprom word width must be 16");
   end

   // synchronised pins and serial clock edge
   logic [3:0] syn;
   logic       sck_s, cs_s, di_s, pe_s, sck_q, rise;

   uw_sync #(.N(4), .STAGES(2)) u_sync (
      .clk (clk), .rst_n (rst_n),
      .din ({pe, di, cs, sck}), .dout (syn)
   );
   assign {pe_s, di_s, cs_s, sck_s} = syn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck_s;
   end
   assign rise = sck_s & ~sck_q;

   // protocol state
   uw_state_t         st;
   logic [1:0]        op_q;
   logic [BC_W-1:0]   bc;
   logic [FLD_W-1:0]  adr_q;
   logic [WORD_W-2:0] dat_q;
   logic              org_q, wen_q, dout_q, oe_q;
   logic [WORD_W-1:0] rd_sh;
   logic [BC_W-1:0]   rd_cnt;
   logic [FLD_W-1:0]  rd_ptr;

   logic [BC_W-1:0]   fld_len, wlen;
   logic [FLD_W-1:0]  adr_n, fa, src, ptr_inc;
   logic [WORD_W-1:0] dat_n, word, fetched, pg_mask, pg_data;
   logic [ADDR_W-1:0] fa_idx, pg_idx;
   logic [BYTE_W-1:0] lane;
   logic [1:0]        ext;
   logic              last_adr, last_dat, allow, busy;
   logic              wr_en, fill_en, tm_start;
   logic [WORD_W-1:0] wr_val, fill_val;
   uw_prog_t          kind;

   assign fld_len  = org_q ? BC_W'(ADDR_W) : BC_W'(FLD_W);
   assign wlen     = org_q ? BC_W'(WORD_W) : BC_W'(BYTE_W);
   assign adr_n    = {adr_q[FLD_W-2:0], di_s};
   assign dat_n    = {dat_q, di_s};
   assign ext      = org_q ? adr_n[ADDR_W-1 -: 2] : adr_n[FLD_W-1 -: 2];
   assign last_adr = (st == ST_ADR) && (bc == fld_len - 1'b1);
   assign last_dat = (st == ST_DAT) && (bc == wlen - 1'b1);
   assign allow    = wen_q & pe_s;

   // read fetch path, shared by the first word and every streamed word
   assign ptr_inc = org_q ? {1'b0, rd_ptr[ADDR_W-1:0] + 1'b1} : rd_ptr + 1'b1;
   assign fa      = (st == ST_RD) ? ptr_inc : adr_n;
   assign fa_idx  = org_q ? fa[ADDR_W-1:0] : fa[FLD_W-1:1];
   assign lane    = fa[0] ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];
   assign fetched = org_q ? word : {lane, {BYTE_W{1'b0}}};

   // programming port
   assign src     = (st == ST_DAT) ? adr_q : adr_n;
   assign pg_idx  = org_q ? src[ADDR_W-1:0] : src[FLD_W-1:1];
   assign pg_mask = org_q ? {WORD_W{1'b1}} :
                    (src[0] ? {{BYTE_W{1'b1}}, {BYTE_W{1'b0}}}
                            : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}});
   assign pg_data = org_q ? dat_n : {2{dat_n[BYTE_W-1:0]}};

   always_comb begin
      wr_en    = 1'b0;
      fill_en  = 1'b0;
      tm_start = 1'b0;
      kind     = PG_WORD;
      wr_val   = pg_data;
      fill_val = pg_data;
      if (rise && cs_s && allow) begin
         if (last_adr && op_q == CMD_ERASE) begin
            wr_en = 1'b1; wr_val = '1; tm_start = 1'b1;
         end else if (last_adr && op_q == CMD_EXT && ext == EXT_ERAL) begin
            fill_en = 1'b1; fill_val = '1; tm_start = 1'b1; kind = PG_ERAL;
         end else if (last_dat && op_q == CMD_WRITE) begin
            wr_en = 1'b1; tm_start = 1'b1;
         end else if (last_dat && op_q == CMD_EXT) begin
            fill_en = 1'b1; tm_start = 1'b1; kind = PG_WRAL;
         end
      end
   end

   uw_store #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_store (
      .clk (clk), .rst_n (rst_n),
      .rd_idx (fa_idx), .rd_word (word),
      .wr_en (wr_en), .wr_idx (pg_idx), .wr_val (wr_val), .wr_mask (pg_mask),
      .fill_en (fill_en), .fill_val (fill_val)
   );

   uw_prog_timer #(.T_WORD(T_WORD), .T_ERAL(T_ERAL), .T_WRAL(T_WRAL)) u_timer (
      .clk (clk), .rst_n (rst_n), .start (tm_start), .kind (kind), .busy (busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         op_q   <= '0;
         bc     <= '0;
         adr_q  <= '0;
         dat_q  <= '0;
         org_q  <= 1'b1;
         wen_q  <= 1'b0;
         dout_q <= 1'b0;
         rd_sh  <= '0;
         rd_cnt <= '0;
         rd_ptr <= '0;
      end else if (!cs_s && (st == ST_OPC || st == ST_ADR || st == ST_DAT || st == ST_RD)) begin
         st <= ST_IDLE;
      end else if (rise && cs_s) begin
         unique case (st)
            ST_IDLE, ST_STAT: begin
               if (di_s && !busy) begin
                  st    <= ST_OPC;
                  bc    <= '0;
                  org_q <= org;
               end
            end
            ST_OPC: begin
               op_q <= {op_q[0], di_s};
               bc   <= bc + 1'b1;
               if (bc == BC_W'(1)) begin
                  st    <= ST_ADR;
                  bc    <= '0;
                  adr_q <= '0;
               end
            end
            ST_ADR: begin
               adr_q <= adr_n;
               bc    <= bc + 1'b1;
               if (last_adr) begin
                  bc <= '0;
                  unique case (op_q)
                     CMD_READ: begin
                        st     <= ST_RD;
                        dout_q <= 1'b0;
                        rd_sh  <= fetched;
                        rd_cnt <= wlen;
                        rd_ptr <= adr_n;
                     end
                     CMD_WRITE: st <= ST_DAT;
                     CMD_ERASE: st <= ST_STAT;
                     default: begin
                        unique case (ext)
                           EXT_ENABLE:  begin wen_q <= 1'b1; st <= ST_IDLE; end
                           EXT_DISABLE: begin wen_q <= 1'b0; st <= ST_IDLE; end
                           EXT_ERAL:    st <= ST_STAT;
                           default:     st <= ST_DAT;
                        endcase
                     end
                  endcase
               end
            end
            ST_DAT: begin
               dat_q <= dat_n[WORD_W-2:0];
               bc    <= bc + 1'b1;
               if (last_dat) st <= ST_STAT;
            end
            ST_RD: begin
               dout_q <= rd_sh[WORD_W-1];
               if (rd_cnt == BC_W'(1)) begin
                  rd_sh  <= fetched;
                  rd_ptr <= ptr_inc;
                  rd_cnt <= wlen;
               end else begin
                  rd_sh  <= {rd_sh[WORD_W-2:0], 1'b0};
                  rd_cnt <= rd_cnt - 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= cs_s && (st == ST_RD || st == ST_STAT);
   end

   assign dout    = (st == ST_STAT) ? ~busy : dout_q;
   assign dout_oe = oe_q;

   AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      dout_oe |-> $past(cs_s)); // R11
   AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RD && $past(st) != ST_RD) |-> !dout_q); // R3
   AST_BUSY_IN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (st == ST_STAT)); // R10
   AST_PROG_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(wen_q) && $past(pe_s))); // R6
endmodule

// File: tb/sim_uw_eeprom.sv
module sim_uw_eeprom;
   localparam int AW = 3;
   localparam int TW = 30;
   localparam int TE = 60;
   localparam int TA = 90;
   localparam int NW = 1 << AW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sck = 1'b0, cs = 1'b0, di = 1'b0, pe = 1'b1, org = 1'b1;
   logic dout, dout_oe;
   int   checks = 0, errs = 0;
   logic [15:0] mdl [NW];

   always #5 clk = ~clk;

   uw_eeprom #(.ADDR_W(AW), .WORD_W(16), .T_WORD(TW), .T_ERAL(TE), .T_WRAL(TA)) u0 (
      .clk (clk), .rst_n (rst_n), .sck (sck), .cs (cs), .di (di),
      .pe (pe), .org (org), .dout (dout), .dout_oe (dout_oe)
   );

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input logic b);
      di = b; cyc(6); sck = 1'b1; cyc(6); sck = 1'b0;
   endtask

   task automatic csl;
      cs = 1'b0; di = 1'b0; cyc(6);
   endtask

   task automatic cmd(input logic [1:0] op, input logic [15:0] a);
      int fw;
      fw = org ? AW : AW + 1;
      cs = 1'b1;
      pulse(1'b1); pulse(op[1]); pulse(op[0]);
      for (int i = fw - 1; i >= 0; i--) pulse(a[i]);
   endtask

   task automatic ext_cmd(input logic [1:0] e);
      cmd(2'b00, org ? (16'(e) << (AW - 2)) : (16'(e) << (AW - 1)));
   endtask

   task automatic shout(input logic [15:0] d, input int n);
      for (int i = n - 1; i >= 0; i--) pulse(d[i]);
   endtask

   task automatic getw(input int n, output logic [15:0] v);
      v = '0;
      for (int i = 0; i < n; i++) begin pulse(1'b0); v = {v[14:0], dout}; end
   endtask

   task automatic wait_prog;
      cyc(TA + 20); csl;
   endtask

   function automatic logic [15:0] mbyte(input int b);
      return (b % 2 == 1) ? {8'h00, mdl[b/2][15:8]} : {8'h00, mdl[b/2][7:0]};
   endfunction

   task automatic rd_chk(input string rq, input logic [15:0] a, input logic [15:0] exp);
      logic [15:0] v;
      cmd(2'b10, a);
      chk({rq, " dummy"}, {dout_oe, dout}, 2'b10);
      getw(org ? 16 : 8, v);
      chk(rq, v, exp);
      csl;
   endtask

   task automatic wr16(input logic [15:0] a, input logic [15:0] d);
      cmd(2'b01, a); shout(d, 16); wait_prog;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++;
      $display("FAIL R10 watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

   initial begin
      logic [15:0] v;
      for (int i = 0; i < NW; i++) mdl[i] = 16'hFFFF;
      cyc(4); rst_n = 1'b1; cyc(4);

      chk("R11 oe after reset", dout_oe, 0);
      rd_chk("R12 blank word", 16'd5, 16'hFFFF);

      // R5 powered up disabled: write is ignored and reports ready
      cmd(2'b01, 16'd2); shout(16'h1234, 16);
      chk("R5 disabled write reports ready", {dout_oe, dout}, 2'b11);
      wait_prog;
      rd_chk("R5 disabled write no effect", 16'd2, 16'hFFFF);

      ext_cmd(2'b11);
      chk("R11 oe off after enable (R2)", dout_oe, 0);
      csl;

      // R7 sweep all words in x16
      for (int a = 0; a < NW; a++) begin
         v = (16'h1357 * 16'(a + 1)) ^ (16'(a) << 12);
         cmd(2'b01, 16'(a)); shout(v, 16);
         if (a == 0) begin
            chk("R10 busy after word write", {dout_oe, dout}, 2'b10);
            cyc(TW + 10);
            chk("R10 ready after word write", {dout_oe, dout}, 2'b11);
         end
         wait_prog;
         mdl[a] = v;
      end
      for (int a = 0; a < NW; a++) rd_chk("R7 R3 x16 word readback", 16'(a), mdl[a]);

      // R4 sequential with wrap in x16
      cmd(2'b10, 16'd6);
      chk("R4 dummy", dout, 0);
      for (int k = 0; k < 4; k++) begin
         getw(16, v);
         chk("R4 x16 stream", v, mdl[(6 + k) % NW]);
      end
      csl;

      // R3 byte view sweep
      org = 1'b0;
      for (int b = 0; b < 2 * NW; b++) rd_chk("R3 R2 x8 byte lane", 16'(b), mbyte(b));
      cmd(2'b10, 16'd14);
      for (int k = 0; k < 3; k++) begin
         getw(8, v);
         chk("R4 x8 stream wrap", v, mbyte((14 + k) % (2 * NW)));
      end
      csl;

      // R7 byte write touches one lane only
      cmd(2'b01, 16'd5); shout(16'h00A5, 8); wait_prog;
      mdl[2][15:8] = 8'hA5;
      org = 1'b1;
      rd_chk("R7 x8 write single lane", 16'd2, mdl[2]);

      cmd(2'b11, 16'd3);
      chk("R10 busy after erase", {dout_oe, dout}, 2'b10);
      wait_prog; mdl[3] = 16'hFFFF;
      rd_chk("R7 erase word", 16'd3, 16'hFFFF);

      org = 1'b0;
      cmd(2'b11, 16'd8); wait_prog; mdl[4][7:0] = 8'hFF;
      org = 1'b1;
      rd_chk("R7 x8 erase byte lane", 16'd4, mdl[4]);

      // R6 protect
      pe = 1'b0; cyc(6);
      cmd(2'b01, 16'd1); shout(16'h0000, 16);
      chk("R6 protected write ready at once", {dout_oe, dout}, 2'b11);
      wait_prog;
      rd_chk("R6 protected word unchanged", 16'd1, mdl[1]);
      ext_cmd(2'b10); wait_prog;
      rd_chk("R6 protected erase-all no effect", 16'd0, mdl[0]);
      pe = 1'b1; cyc(6);

      // R9 incomplete commands
      cmd(2'b01, 16'd4); shout(16'h0F0F, 10); csl;
      rd_chk("R9 cut write not executed", 16'd4, mdl[4]);
      cs = 1'b1; pulse(1'b1); pulse(1'b1); pulse(1'b1); pulse(1'b0); csl;
      rd_chk("R9 cut erase not executed", 16'd0, mdl[0]);

      // R1 activity before a start
      cs = 1'b0; pulse(1'b1); pulse(1'b1); pulse(1'b1);
      cs = 1'b1; pulse(1'b0); pulse(1'b0);
      rd_chk("R1 noise before start ignored", 16'd7, mdl[7]);
      chk("R11 oe off with cs low", dout_oe, 0);

      // R8 erase-all with its own duration
      ext_cmd(2'b10);
      cyc(TW + 10);
      chk("R10 erase-all still busy past word time", {dout_oe, dout}, 2'b10);
      csl;
      chk("R11 status hidden with cs low", dout_oe, 0);
      cs = 1'b1; cyc(TE);
      chk("R10 erase-all ready", {dout_oe, dout}, 2'b11);
      csl;
      for (int i = 0; i < NW; i++) mdl[i] = 16'hFFFF;
      cmd(2'b10, 16'd0);
      for (int k = 0; k < NW; k++) begin getw(16, v); chk("R8 erase-all", v, 16'hFFFF); end
      csl;

      // R8 fill x16, with ignored start while busy
      ext_cmd(2'b01); shout(16'hC3A5, 16);
      pulse(1'b1); pulse(1'b1); pulse(1'b0); pulse(1'b0);
      chk("R10 start ignored while busy", {dout_oe, dout}, 2'b10);
      cyc(TA);
      chk("R10 fill ready, no read started", {dout_oe, dout}, 2'b11);
      csl;
      for (int k = 0; k < NW; k++) rd_chk("R8 fill x16", 16'(k), 16'hC3A5);

      org = 1'b0;
      ext_cmd(2'b01); shout(16'h005A, 8); wait_prog;
      org = 1'b1;
      for (int k = 0; k < NW; k++) rd_chk("R8 fill x8 both lanes", 16'(k), 16'h5A5A);

      // R5 disable again
      ext_cmd(2'b00);
      chk("R11 oe off after disable (R2)", dout_oe, 0);
      csl;
      wr16(16'd3, 16'h0001);
      rd_chk("R5 write after disable ignored", 16'd3, 16'h5A5A);

      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end
endmodule